// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block holds the per-pin routing configuration of an interrupt router and exposes it to software through two bus words. The first word is an 8-bit selector. The second is a 32-bit window. The selector value picks what the window reaches: an identifier word, a read-only version word, an arbitration word, or one half of a 64-bit routing entry for one of the input pins. Software sets the selector first, then reads or writes the window.

Each routing entry carries a vector, a delivery mode, a destination mode, a destination and a mask, all under software control. It also carries two status flags that belong to the delivery logic: a delivery-busy flag and a "waiting for end of interrupt" flag. A window write can never change these two flags. An entry configured for edge triggering always has its waiting flag clear. When a write flips an entry's mask bit, the block pulses a per-pin strobe, and it drives the current mask of every pin as a level. The delivery logic itself is outside this block. It connects through set, clear and busy inputs, one of each per pin.

Bus accesses are single-cycle requests. Read data is registered: it appears in the cycle after a read request and holds until the next read.

Top module: `irq_redir_regs`

## Requirements
- R1: A write to bus offset 0x00 stores bits 7:0 of the write data in the selector, and the upper write bits are dropped. A read of offset 0x00 returns the selector in bits 7:0, with zeros above.
- R2: With selector 0x01, a window read (bus offset 0x10) returns the pin count minus one in bits 23:16, the version code (parameter, default 0x11) in bits 7:0, and zeros elsewhere. Window writes with selector 0x01 change nothing.
- R3: With selector 0x00, the window holds a 4-bit identifier in bits 27:24, with all other bits reading zero; a write loads bits 27:24. With selector 0x02, the window reads the same identifier, and writes there change nothing.
- R4: For a selector value s of 0x10 or above, the window reaches entry (s − 0x10) >> 1. An odd s reaches entry bits 63:32 and an even s reaches bits 31:0. A write replaces only the addressed half.
- R5: A window read with selector 0x03 to 0x0F, or with an entry index at or beyond the pin count, returns 0xFFFFFFFF. A window write there changes no state.
- R6: Entry bit 12 (delivery busy) and bit 14 (waiting for end of interrupt) never take their value from window write data.
- R7: Whenever an entry's bit 15 (trigger mode, 1 = level) is 0, its bit 14 is 0, including immediately after the write that selects edge mode.
- R8: For a level entry, a pulse on rirr_set[p] sets bit 14 of entry p and a pulse on rirr_clr[p] clears it. When both pulse in the same cycle, the clear wins.
- R9: Entry bit 12 of pin p shows dstat_in[p] as registered at the previous clock edge.
- R10: pin_masked[p] equals bit 16 of entry p. mask_toggle[p] pulses for exactly one cycle, in the cycle after a write that changes bit 16 of entry p, and stays low otherwise.
- R11: After reset, every entry reads with bit 16 set and all other bits clear (low half 0x00010000, high half 0). The selector, the identifier and the read data are zero.
- R12: Reads of any bus offset other than 0x00 and 0x10 return zero, and writes there change no state.
- R13: Read data changes only in the cycle after a read request. At all other times it holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Single-cycle access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rirr_set | input | NPINS | Per-pin set of the waiting flag, from the delivery logic |
| rirr_clr | input | NPINS | Per-pin end-of-interrupt clear of the waiting flag |
| dstat_in | input | NPINS | Per-pin delivery-busy level |
| pin_masked | output | NPINS | Current mask bit of each entry |
| mask_toggle | output | NPINS | One-cycle pulse when a write changes an entry's mask |

## Verification
A wrong selector decode or a corrupted entry half shows up at the window on the next read. The bench compares every read against a model kept by the bench, so such a fault is caught within one access. A status flag that leaks from write data, or a waiting flag that survives an edge-mode write, shows up on the first read-back after that write. A missed or extra mask strobe shows up at mask_toggle in the very cycle after the write, and the bench checks it on every cycle.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    localparam int ENTRY_W = 64;
    localparam int WORD_W  = 32;
    localparam int SEL_W   = 8;

    // routing entry field positions
    localparam int F_DSTAT = 12;
    localparam int F_RIRR  = 14;
    localparam int F_TRIG  = 15;
    localparam int F_MASK  = 16;

    localparam logic [ENTRY_W-1:0] ENTRY_RESET = ENTRY_W'(1) << F_MASK;

    // selector codes for the non-entry words
    localparam logic [SEL_W-1:0] SEL_ID    = 8'h00;
    localparam logic [SEL_W-1:0] SEL_VER   = 8'h01;
    localparam logic [SEL_W-1:0] SEL_ARB   = 8'h02;
    localparam logic [SEL_W-1:0] SEL_ENTRY = 8'h10;

    typedef enum logic [2:0] {
        WK_ID,
        WK_VER,
        WK_ARB,
        WK_ENTRY,
        WK_NONE
    } win_kind_e;

    typedef struct packed {
        logic [ENTRY_W-1:0] ent;
        logic               tog;
    } ent_state_t;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [3:0]        id;
        logic [WORD_W-1:0] rdata;
    } top_state_t;

endpackage

// File: rtl/irq_redir_sel_dec.sv
module irq_redir_sel_dec
    import irq_redir_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic [SEL_W-1:0] sel,
    output win_kind_e        kind,
    output logic [SEL_W-1:0] idx,
    output logic             hi
);

    logic [SEL_W-1:0] off;

    always_comb begin
        off  = sel - SEL_ENTRY;
        idx  = {1'b0, off[SEL_W-1:1]};
        hi   = sel[0];
        kind = WK_NONE;
        if (sel == SEL_ID) begin
            kind = WK_ID;
        end else if (sel == SEL_VER) begin
            kind = WK_VER;
        end else if (sel == SEL_ARB) begin
            kind = WK_ARB;
        end else if (sel >= SEL_ENTRY) begin
            if (int'(idx) < NPINS) begin
                kind = WK_ENTRY;
            end
        end
    end

endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
    import irq_redir_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_hi,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               rirr_set,
    input  logic               rirr_clr,
    input  logic               dstat_in,
    output logic [ENTRY_W-1:0] entry_q,
    output logic               toggle_q
);

    ent_state_t cur_q, nxt_d;
    logic [ENTRY_W-1:0] e;

    always_comb begin
        nxt_d = cur_q;
        e     = cur_q.ent;
        if (wr_en) begin
            if (wr_hi) begin
                e[ENTRY_W-1:WORD_W] = wr_data;
            end else begin
                e[WORD_W-1:0] = wr_data;
            end
        end
        // hardware-owned flags never come from write data
        e[F_DSTAT] = dstat_in;
        if (e[F_TRIG]) begin
            e[F_RIRR] = (cur_q.ent[F_RIRR] | rirr_set) & ~rirr_clr;
        end else begin
            e[F_RIRR] = 1'b0;
        end
        nxt_d.tog = e[F_MASK] ^ cur_q.ent[F_MASK];
        nxt_d.ent = e;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.ent <= ENTRY_RESET;
            cur_q.tog <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign entry_q  = cur_q.ent;
    assign toggle_q = cur_q.tog;

endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
    import irq_redir_pkg::*;
#(
    parameter int          NPINS    = 24,
    parameter logic [7:0]  VERSION  = 8'h11,
    parameter logic [7:0]  SEL_OFF  = 8'h00,
    parameter logic [7:0]  WIN_OFF  = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  rirr_set,
    input  logic [NPINS-1:0]  rirr_clr,
    input  logic [NPINS-1:0]  dstat_in,
    output logic [NPINS-1:0]  pin_masked,
    output logic [NPINS-1:0]  mask_toggle
);

    localparam logic [7:0] LAST_PIN = 8'(NPINS - 1);
    localparam logic [WORD_W-1:0] VER_WORD = {8'h00, LAST_PIN, 8'h00, VERSION};

    top_state_t cur_q, nxt_d;

    win_kind_e        kind;
    logic [SEL_W-1:0] idx;
    logic             hi;
    logic             sel_wr, win_wr, win_rd, sel_rd;
    logic [ENTRY_W-1:0] ent_q [NPINS];
    logic [WORD_W-1:0]  win_word;
    logic [SEL_W-1:0]   sel_q;

    irq_redir_sel_dec #(.NPINS(NPINS)) u_dec (
        .sel  (cur_q.sel),
        .kind (kind),
        .idx  (idx),
        .hi   (hi)
    );

    assign sel_wr = bus_valid &  bus_write & (bus_addr == SEL_OFF);
    assign win_wr = bus_valid &  bus_write & (bus_addr == WIN_OFF);
    assign sel_rd = bus_valid & ~bus_write & (bus_addr == SEL_OFF);
    assign win_rd = bus_valid & ~bus_write & (bus_addr == WIN_OFF);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic wr_this;
        assign wr_this = win_wr & (kind == WK_ENTRY) & (idx == SEL_W'(p));

        irq_redir_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_this),
            .wr_hi    (hi),
            .wr_data  (bus_wdata),
            .rirr_set (rirr_set[p]),
            .rirr_clr (rirr_clr[p]),
            .dstat_in (dstat_in[p]),
            .entry_q  (ent_q[p]),
            .toggle_q (mask_toggle[p])
        );

        assign pin_masked[p] = ent_q[p][F_MASK];
    end

    // window read word
    always_comb begin
        win_word = '1;
        case (kind)
            WK_ID, WK_ARB: win_word = {4'h0, cur_q.id, 24'h0};
            WK_VER:        win_word = VER_WORD;
            WK_ENTRY: begin
                for (int p = 0; p < NPINS; p++) begin
                    if (idx == SEL_W'(p)) begin
                        win_word = hi ? ent_q[p][ENTRY_W-1:WORD_W] : ent_q[p][WORD_W-1:0];
                    end
                end
            end
            default:       win_word = '1;
        endcase
    end

    always_comb begin
        nxt_d = cur_q;
        if (sel_wr) begin
            nxt_d.sel = bus_wdata[SEL_W-1:0];
        end
        if (win_wr && kind == WK_ID) begin
            nxt_d.id = bus_wdata[27:24];
        end
        if (bus_valid && !bus_write) begin
            if (sel_rd) begin
                nxt_d.rdata = {24'h0, cur_q.sel};
            end else if (win_rd) begin
                nxt_d.rdata = win_word;
            end else begin
                nxt_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign bus_rdata = cur_q.rdata;
    assign sel_q     = cur_q.sel;

endmodule

// File: rtl/irq_redir_regs_chk.sv
module irq_redir_regs_chk
    import irq_redir_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter logic [7:0] SEL_OFF = 8'h00,
    parameter logic [7:0] WIN_OFF = 8'h10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [7:0]         bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [NPINS-1:0]   pin_masked,
    input logic [NPINS-1:0]   mask_toggle,
    input logic [SEL_W-1:0]   sel_q,
    input logic [ENTRY_W-1:0] ent [NPINS]
);

    logic rd_req, oor_rd, other_rd;
    assign rd_req   = bus_valid & ~bus_write;
    assign oor_rd   = rd_req & (bus_addr == WIN_OFF) &
                      ((int'(sel_q) >= 16 + 2 * NPINS) || (sel_q > 8'h02 && sel_q < 8'h10));
    assign other_rd = rd_req & (bus_addr != WIN_OFF) & (bus_addr != SEL_OFF);

    AST_SEL_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == SEL_OFF) |=> sel_q == $past(bus_wdata[7:0])); // R1

    AST_OOR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        oor_rd |=> bus_rdata == 32'hFFFF_FFFF); // R5

    AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        other_rd |=> bus_rdata == 32'h0); // R12

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(bus_rdata)); // R13

    for (genvar p = 0; p < NPINS; p++) begin : g_chk
        AST_EDGE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
            !ent[p][F_TRIG] |-> !ent[p][F_RIRR]); // R7

        AST_MASK_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
            pin_masked[p] == ent[p][F_MASK]); // R10

        AST_TOGGLE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
            mask_toggle[p] |-> pin_masked[p] != $past(pin_masked[p])); // R10
    end

endmodule

bind irq_redir_regs irq_redir_regs_chk #(
    .NPINS   (NPINS),
    .SEL_OFF (SEL_OFF),
    .WIN_OFF (WIN_OFF)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pin_masked  (pin_masked),
    .mask_toggle (mask_toggle),
    .sel_q       (sel_q),
    .ent         (ent_q)
);

// File: tb/irq_redir_regs_bench.sv
module irq_redir_regs_bench;

    localparam int NP = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] rirr_set = '0;
    logic [NP-1:0] rirr_clr = '0;
    logic [NP-1:0] dstat_in = '0;
    logic [NP-1:0] pin_masked;
    logic [NP-1:0] mask_toggle;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [63:0] m_ent [NP];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    logic [31:0] m_rd;

    always #4 clk = ~clk;

    irq_redir_regs u_irq_redir_regs (
        .clk (clk), .rst_n (rst_n),
        .bus_valid (bus_valid), .bus_write (bus_write), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .rirr_set (rirr_set), .rirr_clr (rirr_clr), .dstat_in (dstat_in),
        .pin_masked (pin_masked), .mask_toggle (mask_toggle)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [7:0] ix;
        if (a == 8'h00) return {24'h0, m_sel};
        if (a != 8'h10) return 32'h0;
        if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
        if (m_sel == 8'h01) return {8'h00, 8'(NP - 1), 8'h00, 8'h11};
        if (m_sel < 8'h10) return 32'hFFFF_FFFF;
        ix = (m_sel - 8'h10) >> 1;
        if (int'(ix) >= NP) return 32'hFFFF_FFFF;
        return m_sel[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
    endfunction

    // one bus cycle with the model stepped alongside
    task automatic cycle(input string tag, input logic v, input logic w, input logic [7:0] a,
                         input logic [31:0] d, input logic [NP-1:0] st, input logic [NP-1:0] cl);
        logic [NP-1:0] exp_tog;
        logic [NP-1:0] exp_msk;
        logic [7:0]    ix;
        logic [63:0]   e;
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        rirr_set = st; rirr_clr = cl;
        if (v && !w) m_rd = model_read(a);
        ix = (m_sel - 8'h10) >> 1;
        for (int p = 0; p < NP; p++) begin
            e = m_ent[p];
            if (v && w && a == 8'h10 && m_sel >= 8'h10 && int'(ix) == p) begin
                if (m_sel[0]) e[63:32] = d; else e[31:0] = d;
            end
            e[12] = dstat_in[p];
            e[14] = e[15] ? ((m_ent[p][14] | st[p]) & ~cl[p]) : 1'b0;
            exp_tog[p] = e[16] ^ m_ent[p][16];
            m_ent[p] = e;
            exp_msk[p] = e[16];
        end
        if (v && w && a == 8'h10 && m_sel == 8'h00) m_id = d[27:24];
        if (v && w && a == 8'h00) m_sel = d[7:0];
        @(posedge clk);
        #1;
        bus_valid = 1'b0; rirr_set = '0; rirr_clr = '0;
        check({tag, " rdata"}, bus_rdata, m_rd);
        check("R10 toggle", 32'(mask_toggle), 32'(exp_tog));
        check("R10 mask", 32'(pin_masked), 32'(exp_msk));
    endtask

    task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d);
        cycle(tag, 1'b1, 1'b1, a, d, '0, '0);
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        cycle(tag, 1'b1, 1'b0, a, 32'h0, '0, '0);
    endtask

    task automatic idle(input string tag, input logic [NP-1:0] st, input logic [NP-1:0] cl);
        cycle(tag, 1'b0, 1'b0, 8'h00, 32'h0, st, cl);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [NP-1:0] p1;
        void'($urandom(32'h5EED_1234));
        for (int p = 0; p < NP; p++) m_ent[p] = 64'h0000_0000_0001_0000;
        m_sel = '0; m_id = '0; m_rd = '0;
        p1 = NP'(1) << 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        check("R11 masks", 32'(pin_masked), 32'(NP'('1)));
        check("R11 rdata", bus_rdata, 32'h0);
        rd("R11 sel", 8'h00);
        check("R11 sel zero", bus_rdata, 32'h0);
        wr("R1", 8'h00, 32'h0000_0010);
        rd("R11 entry low", 8'h10);
        check("R11 entry low literal", bus_rdata, 32'h0001_0000);
        wr("R1", 8'h00, 32'h0000_0011);
        rd("R11 entry high", 8'h10);

        // R1 selector keeps the low byte
        wr("R1", 8'h00, 32'hABCD_01A5);
        rd("R1 sel", 8'h00);
        check("R1 sel literal", bus_rdata, 32'h0000_00A5);

        // R2 version word
        wr("R2", 8'h00, 32'h1);
        rd("R2 ver", 8'h10);
        check("R2 ver literal", bus_rdata, 32'h0017_0011);
        wr("R2", 8'h10, 32'hFFFF_FFFF);
        rd("R2 ver after write", 8'h10);

        // R3 identifier and arbitration
        wr("R3", 8'h00, 32'h0);
        wr("R3", 8'h10, 32'hF5FF_FFFF);
        rd("R3 id", 8'h10);
        check("R3 id literal", bus_rdata, 32'h0500_0000);
        wr("R3", 8'h00, 32'h2);
        wr("R3", 8'h10, 32'h0A00_0000);
        rd("R3 arb", 8'h10);
        check("R3 arb literal", bus_rdata, 32'h0500_0000);

        // R4 / R6 / R10 entry 1 low half, level, unmasked
        wr("R4", 8'h00, 32'h12);
        wr("R6", 8'h10, 32'h0000_D0F3);
        rd("R6 readback", 8'h10);
        check("R6 literal", bus_rdata, 32'h0000_80F3);
        wr("R4", 8'h00, 32'h13);
        wr("R4", 8'h10, 32'hAB00_0000);
        rd("R4 high", 8'h10);
        wr("R4", 8'h00, 32'h12);
        rd("R4 low intact", 8'h10);

        // R8 set then write preserves, R7 edge clears
        idle("R8 set", p1, '0);
        rd("R8 after set", 8'h10);
        check("R8 literal", bus_rdata, 32'h0000_C0F3);
        wr("R6", 8'h10, 32'h0000_80F3);
        rd("R6 keep wait flag", 8'h10);
        wr("R7", 8'h10, 32'h0000_00F3);
        rd("R7 edge cleared", 8'h10);
        check("R7 literal", bus_rdata, 32'h0000_00F3);
        idle("R7 set ignored", p1, '0);
        rd("R7 stays clear", 8'h10);
        wr("R8", 8'h10, 32'h0000_80F3);
        idle("R8 set", p1, '0);
        idle("R8 set and clear", p1, p1);
        rd("R8 clear wins", 8'h10);

        // R9 busy mirror
        dstat_in = p1;
        idle("R9", '0, '0);
        wr("R9", 8'h10, 32'h0000_80F3);
        rd("R9 busy", 8'h10);
        dstat_in = '0;
        idle("R9", '0, '0);
        rd("R9 idle", 8'h10);

        // R10 mask toggle back
        wr("R10", 8'h10, 32'h0001_80F3);

        // last pin and out-of-range selectors (R5)
        wr("R4", 8'h00, 32'h3E);
        wr("R4", 8'h10, 32'h0000_0042);
        wr("R4", 8'h00, 32'h3F);
        wr("R4", 8'h10, 32'h7700_0000);
        rd("R4 last pin", 8'h10);
        wr("R5", 8'h00, 32'h40);
        rd("R5 oor", 8'h10);
        check("R5 literal", bus_rdata, 32'hFFFF_FFFF);
        wr("R5", 8'h10, 32'h0000_0000);
        wr("R5", 8'h00, 32'h05);
        rd("R5 gap", 8'h10);
        wr("R5", 8'h10, 32'h0000_0000);

        // R12 other offsets
        rd("R12 other", 8'h04);
        check("R12 literal", bus_rdata, 32'h0);
        wr("R12", 8'h08, 32'hFFFF_FFFF);
        rd("R12 sel unchanged", 8'h00);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            logic [NP-1:0] st;
            logic [NP-1:0] cl;
            r = $urandom_range(0, 9);
            st = ($urandom_range(0, 3) == 0) ? NP'($urandom) : '0;
            cl = ($urandom_range(0, 3) == 0) ? NP'($urandom) : '0;
            if ($urandom_range(0, 7) == 0) dstat_in = NP'($urandom);
            case (r)
                0, 1: cycle("R1", 1'b1, 1'b1, 8'h00,
                            {24'($urandom), 8'($urandom_range(0, 8'h44))}, st, cl);
                2, 3, 4: cycle("R4", 1'b1, 1'b1, 8'h10, $urandom, st, cl);
                5, 6, 7: cycle("R4", 1'b1, 1'b0, 8'h10, 32'h0, st, cl);
                8: cycle("R13", 1'b0, 1'b0, 8'h00, 32'h0, st, cl);
                default: cycle("R12", 1'b1, $urandom_range(0, 1) == 1,
                               8'($urandom_range(0, 3)) << 2, $urandom, st, cl);
            endcase
        end

        // sweep all entries through the window
        for (int s = 8'h10; s < 8'h10 + 2 * NP; s++) begin
            wr("R4", 8'h00, 32'(s));
            rd("R4 sweep", 8'h10);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule